// File: doc/BRIEF.md
# Bidirectional Control Endpoint FIFO

The block is a single 16-entry, 8-bit FIFO for the control endpoint of a USB device. One storage array serves both directions. The protocol-side controller picks the direction; the processor cannot. While a host command is arriving, the protocol side pushes its bytes and the processor pops them through a data read port. When the command asks for a data stage back to the host, the processor pushes the response bytes and the protocol side pops them.

A three-phase sequencer (idle, command receive, response transmit) gates every port. A processor write counts only during the response phase. A processor read outside the receive phase returns zero and leaves the FIFO as it was. Entering a new receive phase empties the storage and clears the error flags, so leftover response bytes never mix with a new command. Occupancy is reported as a count that holds one less than the number of bytes stored, together with a separate empty flag.

Top module: `ctl_ep_fifo`

## Requirements
- R1: After reset, phase_o is 0 (idle), empty_o is 1, full_o is 0, count_o is 0, and ovf_o and unf_o are 0.
- R2: In idle, a pulse on cmd_start_i moves phase_o to 1 (receive) at the next edge. The same edge empties the FIFO and clears ovf_o and unf_o.
- R3: In receive, pr_push_i stores pr_wdata_i and cpu_rd_i pops the oldest byte. cpu_rdata_o shows the oldest byte combinationally. count_o is the number of stored bytes minus one, and empty_o is 1 with count_o 0 when nothing is stored.
- R4: In receive, cmd_valid_i with need_resp_i set moves phase_o to 2 (transmit). cmd_valid_i with need_resp_i clear returns phase_o to 0.
- R5: In transmit, cpu_wr_i stores cpu_wdata_i, pr_pop_i pops in first-in first-out order (pr_rdata_o shows the oldest byte), and xfer_done_i returns phase_o to 0.
- R6: cpu_wr_i outside transmit has no effect on the FIFO contents or count.
- R7: cpu_rd_i outside receive gives cpu_rdata_o = 0 and leaves count_o and empty_o unchanged.
- R8: pr_push_i outside receive, and pr_pop_i outside transmit, are ignored. pr_rdata_o is 0 outside transmit.
- R9: A push while 16 bytes are stored, with no pop in the same cycle, is dropped and sets the sticky ovf_o.
- R10: A pop while empty returns 0 on the read port and sets the sticky unf_o.
- R11: A push and a pop in the same cycle, from the two sides allowed by the phase, leave the count unchanged, even when the FIFO is full.
- R12: The FIFO holds exactly 16 bytes. full_o is 1 and count_o is 15 at that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Protocol side: a new command begins |
| cmd_valid_i | input | 1 | Protocol side: the command is complete and valid |
| need_resp_i | input | 1 | The valid command needs a data stage to the host |
| xfer_done_i | input | 1 | Protocol side: the response has been sent |
| pr_push_i | input | 1 | Protocol-side push (receive) |
| pr_wdata_i | input | 8 | Protocol-side push data |
| pr_pop_i | input | 1 | Protocol-side pop (transmit) |
| pr_rdata_o | output | 8 | Oldest byte for the protocol side, 0 when not in transmit |
| cpu_rd_i | input | 1 | Processor data-port read (pop) |
| cpu_rdata_o | output | 8 | Processor read data, 0 when not in receive |
| cpu_wr_i | input | 1 | Processor data-port write (push) |
| cpu_wdata_i | input | 8 | Processor write data |
| count_o | output | 8 | Stored bytes minus one |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| ovf_o | output | 1 | Sticky overflow |
| unf_o | output | 1 | Sticky underflow |
| phase_o | output | 2 | 0 idle, 1 receive, 2 transmit |

## Verification
The bench fills the FIFO to exactly 16 bytes and then pushes once more. A design with an off-by-one depth or no drop guard would either store the extra byte or lose one of the bytes it should keep. It pushes and pops together while the FIFO is full; a design that checks fullness before crediting the pop would refuse the push and let the count fall. It tries processor writes outside transmit, reads outside receive, and wrong-side pushes and pops in every phase, where a design with loose gating would change the count or return a stale byte. It starts a new command over leftover bytes and set error flags; a design without the flush would hand stale data to the processor and keep the old flags.

// File: rtl/ctl_ep_fifo_pkg.sv
package ctl_ep_fifo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RX   = 2'd1,
    PH_TX   = 2'd2
  } ep_phase_e;
endpackage

// File: rtl/ctl_ep_phase_fsm.sv
module ctl_ep_phase_fsm
  import ctl_ep_fifo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_start_i,
  input  logic      cmd_valid_i,
  input  logic      need_resp_i,
  input  logic      xfer_done_i,
  output ep_phase_e phase_o,
  output logic      flush_o
);
  ep_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    flush_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (cmd_start_i) begin
        phase_d = PH_RX;
        flush_o = 1'b1;
      end
      PH_RX: if (cmd_valid_i) phase_d = need_resp_i ? PH_TX : PH_IDLE;
      PH_TX: if (xfer_done_i) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  assert_start_to_rx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && cmd_start_i) |=> (phase_q == PH_RX));
  assert_rx_to_tx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RX && cmd_valid_i && need_resp_i) |=> (phase_q == PH_TX));
  assert_rx_to_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RX && cmd_valid_i && !need_resp_i) |=> (phase_q == PH_IDLE));
  assert_tx_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TX && xfer_done_i) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/ctl_ep_ring.sv
module ctl_ep_ring #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_drop_o,
  output logic          pop_miss_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign pop_ok  = pop_i && !empty_o;
  // a same-cycle pop frees the slot, so a full FIFO still takes the push
  assign push_ok = push_i && (!full_o || pop_ok);
  assign push_drop_o = push_i && !push_ok;
  assign pop_miss_o  = pop_i && !pop_ok;
  assign rdata_o = empty_o ? '0 : mem_q[rd_q];
  assign level_o = lvl_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_ok && wr_q == AW'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      if (push_ok && !pop_ok)      lvl_q <= lvl_q + LW'(1);
      else if (pop_ok && !push_ok) lvl_q <= lvl_q - LW'(1);
    end
  end

  assert_level_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LW'(DEPTH));
  assert_flush_empties_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
  assert_simul_level_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o && !flush_i) |=> $stable(lvl_q));
endmodule

// File: rtl/ctl_ep_fifo.sv
module ctl_ep_fifo
  import ctl_ep_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_start_i,
  input  logic          cmd_valid_i,
  input  logic          need_resp_i,
  input  logic          xfer_done_i,
  input  logic          pr_push_i,
  input  logic [DW-1:0] pr_wdata_i,
  input  logic          pr_pop_i,
  output logic [DW-1:0] pr_rdata_o,
  input  logic          cpu_rd_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic [1:0]    phase_o
);
  localparam int LW = $clog2(DEPTH + 1);

  ep_phase_e     phase;
  logic          flush, rx, tx;
  logic          push, pop, drop, miss;
  logic [DW-1:0] wdata, head;
  logic [LW-1:0] level;
  logic          ovf_q, unf_q;

  ctl_ep_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_start_i(cmd_start_i),
    .cmd_valid_i(cmd_valid_i),
    .need_resp_i(need_resp_i),
    .xfer_done_i(xfer_done_i),
    .phase_o    (phase),
    .flush_o    (flush)
  );

  assign rx = (phase == PH_RX);
  assign tx = (phase == PH_TX);

  // direction steering: receive = protocol in / cpu out, transmit = cpu in / protocol out
  always_comb begin
    push  = 1'b0;
    pop   = 1'b0;
    wdata = '0;
    if (rx) begin
      push  = pr_push_i;
      wdata = pr_wdata_i;
      pop   = cpu_rd_i;
    end else if (tx) begin
      push  = cpu_wr_i;
      wdata = cpu_wdata_i;
      pop   = pr_pop_i;
    end
  end

  ctl_ep_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .push_i     (push),
    .wdata_i    (wdata),
    .pop_i      (pop),
    .rdata_o    (head),
    .level_o    (level),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .push_drop_o(drop),
    .pop_miss_o (miss)
  );

  assign cpu_rdata_o = rx ? head : '0;
  assign pr_rdata_o  = tx ? head : '0;
  assign count_o     = empty_o ? '0 : CW'(level - LW'(1));
  assign phase_o     = phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (flush) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (drop) ovf_q <= 1'b1;
      if (miss) unf_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  assert_rd_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx && cpu_rd_i && !pr_push_i && !pr_pop_i && !cpu_wr_i && !cmd_start_i) |=> $stable(count_o));
  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE && !cmd_start_i) |=> $stable(count_o) && $stable(empty_o));
  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !flush) |=> ovf_q);
  assert_unf_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx && cpu_rd_i && empty_o) |=> unf_q);
  assert_flags_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (!ovf_q && !unf_q));
endmodule

// File: tb/ctl_ep_fifo_bench.sv
module ctl_ep_fifo_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_start, cmd_valid, need_resp, xfer_done;
  logic pr_push, pr_pop, cpu_rd, cpu_wr;
  logic [7:0] pr_wdata, cpu_wdata, pr_rdata, cpu_rdata, count;
  logic empty, full, ovf, unf;
  logic [1:0] phase;
  logic [7:0] cap_cpu, cap_pr;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  ctl_ep_fifo u_ctl_ep_fifo (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_start_i(cmd_start), .cmd_valid_i(cmd_valid),
    .need_resp_i(need_resp), .xfer_done_i(xfer_done),
    .pr_push_i(pr_push), .pr_wdata_i(pr_wdata), .pr_pop_i(pr_pop), .pr_rdata_o(pr_rdata),
    .cpu_rd_i(cpu_rd), .cpu_rdata_o(cpu_rdata), .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata),
    .count_o(count), .empty_o(empty), .full_o(full), .ovf_o(ovf), .unf_o(unf),
    .phase_o(phase)
  );

  // {push, wdata, pop, exp_cpu_rdata, exp_count, exp_empty}, all in receive phase
  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 8'h00, 8'd0, 1'b0},
    {1'b1, 8'h22, 1'b0, 8'h11, 8'd1, 1'b0},
    {1'b1, 8'h33, 1'b1, 8'h11, 8'd1, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h22, 8'd0, 1'b0},
    {1'b1, 8'h44, 1'b1, 8'h33, 8'd0, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h44, 8'd0, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    cmd_start = 0; cmd_valid = 0; need_resp = 0; xfer_done = 0;
    pr_push = 0; pr_pop = 0; cpu_rd = 0; cpu_wr = 0;
    pr_wdata = 0; cpu_wdata = 0;
  endtask

  // inputs set at a falling edge; read ports captured 1 time unit later; one clock
  task automatic tick();
    #1;
    cap_cpu = cpu_rdata;
    cap_pr  = pr_rdata;
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    clear_in();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    chk("R1 phase", {6'd0, phase}, 8'd0);
    chk("R1 empty", {7'd0, empty}, 8'd1);
    chk("R1 full", {7'd0, full}, 8'd0);
    chk("R1 count", count, 8'd0);
    chk("R1 flags", {6'd0, ovf, unf}, 8'd0);

    cpu_wr = 1; cpu_wdata = 8'h99; tick();
    chk("R6 idle write empty", {7'd0, empty}, 8'd1);

    cmd_start = 1; tick();
    chk("R2 phase rx", {6'd0, phase}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      pr_push = VEC[i][26]; pr_wdata = VEC[i][25:18]; cpu_rd = VEC[i][17];
      tick();
      chk($sformatf("R3 vec%0d rdata", i), cap_cpu, VEC[i][16:9]);
      chk($sformatf("R11 vec%0d count", i), count, VEC[i][8:1]);
      chk($sformatf("R3 vec%0d empty", i), {7'd0, empty}, {7'd0, VEC[i][0]});
    end

    cpu_wr = 1; cpu_wdata = 8'h77; tick();
    chk("R6 rx write ignored", {7'd0, empty}, 8'd1);

    for (int i = 0; i < 16; i++) begin
      pr_push = 1; pr_wdata = 8'h80 + 8'(i); tick();
    end
    chk("R12 full", {7'd0, full}, 8'd1);
    chk("R12 count", count, 8'd15);
    pr_push = 1; pr_wdata = 8'hEE; tick();
    chk("R9 ovf", {7'd0, ovf}, 8'd1);
    chk("R9 count", count, 8'd15);
    pr_push = 1; pr_wdata = 8'hFF; cpu_rd = 1; tick();
    chk("R11 full simul rdata", cap_cpu, 8'h80);
    chk("R11 full simul count", count, 8'd15);
    for (int i = 1; i < 16; i++) begin
      cpu_rd = 1; tick();
      chk($sformatf("R9 drain %0d", i), cap_cpu, 8'h80 + 8'(i));
    end
    cpu_rd = 1; tick();
    chk("R11 pushed byte kept", cap_cpu, 8'hFF);
    cpu_rd = 1; tick();
    chk("R10 empty read zero", cap_cpu, 8'h00);
    chk("R10 unf", {7'd0, unf}, 8'd1);

    cmd_valid = 1; need_resp = 1; tick();
    chk("R4 phase tx", {6'd0, phase}, 8'd2);
    pr_push = 1; pr_wdata = 8'h55; tick();
    chk("R8 tx pr_push ignored", {7'd0, empty}, 8'd1);
    pr_pop = 1; tick();
    chk("R10 tx empty pop zero", cap_pr, 8'h00);
    cpu_wr = 1; cpu_wdata = 8'hA0; tick();
    cpu_wr = 1; cpu_wdata = 8'hA1; tick();
    cpu_wr = 1; cpu_wdata = 8'hA2; tick();
    chk("R5 tx count", count, 8'd2);
    cpu_rd = 1; tick();
    chk("R7 tx read zero", cap_cpu, 8'h00);
    chk("R7 tx read count", count, 8'd2);
    cpu_wr = 1; cpu_wdata = 8'hA3; pr_pop = 1; tick();
    chk("R5 tx pop0", cap_pr, 8'hA0);
    chk("R11 tx simul count", count, 8'd2);
    for (int i = 1; i < 4; i++) begin
      pr_pop = 1; tick();
      chk($sformatf("R5 tx pop%0d", i), cap_pr, 8'hA0 + 8'(i));
    end
    chk("R5 tx drained", {7'd0, empty}, 8'd1);
    chk("R9 ovf sticky", {7'd0, ovf}, 8'd1);
    cpu_wr = 1; cpu_wdata = 8'hB0; tick();
    xfer_done = 1; tick();
    chk("R5 phase idle", {6'd0, phase}, 8'd0);

    chk("R8 idle pr_rdata zero", pr_rdata, 8'h00);
    pr_pop = 1; tick();
    chk("R8 idle pop ignored", count, 8'd0);
    chk("R8 idle pop empty", {7'd0, empty}, 8'd0);

    cmd_start = 1; tick();
    chk("R2 stale flushed", {7'd0, empty}, 8'd1);
    chk("R2 flags cleared", {6'd0, ovf, unf}, 8'd0);
    pr_push = 1; pr_wdata = 8'h5A; tick();
    cmd_valid = 1; need_resp = 0; tick();
    chk("R4 no resp idle", {6'd0, phase}, 8'd0);
    cpu_rd = 1; tick();
    chk("R7 idle read zero", cap_cpu, 8'h00);
    chk("R7 idle read count", count, 8'd0);
    chk("R7 idle read empty", {7'd0, empty}, 8'd0);
    cmd_start = 1; tick();
    chk("R2 rx flush", {7'd0, empty}, 8'd1);
    chk("R3 rx read after flush", cpu_rdata, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule